// File: doc/BRIEF.md
# Serial Link Fault Monitor

This block derives a link fault status for each channel of a receiver of 10-bit characters. Each channel takes its recovered serial stream one bit per clock, qualified by a valid strobe. It counts how many valid bits in a row carry the same value. A run longer than six characters means the stream has lost its transitions, and the channel reports a fault.

The fault is also forced on in four other cases. The first is when the channel is switched off. The second is when an upstream rate monitor signals that it is steering the receive oscillator onto the reference clock. The third is when an external signal-detect input reports loss of signal. The fourth is a programmable blanking interval that follows each re-enable of the channel. The status pin is active low, so system logic can use it directly to pick an alternate input path. The default build has two independent channels.

Top module: `link_fault_mon`

## Requirements
- R1: A channel reports a fault once it has received more than 60 consecutive valid bits of equal value. The 61st such bit sets the fault. A run of exactly 60 leaves the fault clear.
- R2: The run counter saturates and does not wrap, so a run of any length (for example 300 bits) keeps the fault set.
- R3: The fault from R1 or R11 clears on the first valid bit that differs from the previous valid bit, unless another fault condition is still active.
- R4: Bits presented while the valid strobe of that channel is low are ignored. They neither advance nor reset the run, and they do not clear a fault.
- R5: The status output fault_no is active low. A value of 0 means a fault and a value of 1 means the link is good.
- R6: While ch_en_i of a channel is 0, its fault_no is 0 in the same cycle. A disabled channel restarts its detector in the fault state, and after re-enable the fault clears only through R3.
- R7: While rate_force_i of a channel is 1, its fault_no is 0 in the same cycle.
- R8: While sig_lost_i of a channel is 1, its fault_no is 0 in the same cycle.
- R9: On the first clock edge at which ch_en_i is seen high after being low, the channel loads blank_len_i. The channel then holds fault_no at 0 for that many further clock edges. A value of 0 gives no blanking. Reset counts as the previous low state.
- R10: Channels are independent. Stimulus on one channel never changes the status of another.
- R11: Reset puts every channel in the fault state with its run counter at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | NUM_CH | Recovered serial bit, one per channel |
| bit_vld_i | input | NUM_CH | Valid strobe for bit_i, one per channel |
| ch_en_i | input | NUM_CH | Channel enable, 0 = disabled |
| rate_force_i | input | NUM_CH | Rate monitor is forcing the oscillator to the reference |
| sig_lost_i | input | NUM_CH | External loss-of-signal indication |
| blank_len_i | input | BLANK_W | Blanking length in cycles after re-enable |
| fault_no | output | NUM_CH | Link fault status, active low |

## Verification
A run counter stuck or wrapped early would show at fault_no within one run length. Either the pin drops before the 61st equal bit, or it rises again partway through a long run, which a 300-bit run exposes. A stale flag or previous-bit register holding a wrong value would keep the pin low after a real transition, or release it on a bit that repeats its predecessor. Each of these shows on the first edge that follows the offending bit. An off-by-one in the blanking timer shifts the rising edge of fault_no by one cycle after re-enable, so the bench samples both cycles around that expected release edge.

// File: rtl/lfm_pkg.sv
package lfm_pkg;
  parameter int unsigned DEF_CHAR_BITS = 10;
  parameter int unsigned DEF_RUN_CHARS = 6;

  // width able to hold 0 .. lim+1
  function automatic int unsigned run_cnt_w(input int unsigned lim);
    return $clog2(lim + 2);
  endfunction
endpackage

// File: rtl/lfm_run_det.sv
module lfm_run_det #(
  parameter int unsigned LIMIT = 60,
  parameter int unsigned CW    = lfm_pkg::run_cnt_w(LIMIT)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic vld_i,
  input  logic bit_i,
  output logic flt_o
);
  localparam logic [CW-1:0] LIM_C = CW'(LIMIT);
  localparam logic [CW-1:0] MAX_C = CW'(LIMIT + 1);

  logic          stale_q;
  logic          have_q;
  logic          prev_q;
  logic [CW-1:0] cnt_q;
  logic          edge_s;

  assign edge_s = have_q && (bit_i != prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stale_q <= 1'b1;
      have_q  <= 1'b0;
      prev_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (clr_i) begin
      stale_q <= 1'b1;
      have_q  <= 1'b0;
      prev_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (vld_i) begin
      have_q <= 1'b1;
      prev_q <= bit_i;
      if (edge_s) begin
        stale_q <= 1'b0;
        cnt_q   <= CW'(1);
      end else if (cnt_q != MAX_C) begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign flt_o = stale_q | (cnt_q > LIM_C);

  a_r2_cnt_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= MAX_C);

  a_r3_edge_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !clr_i && edge_s) |=> !flt_o);

  a_r4_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_i && !clr_i) |=> $stable(cnt_q) && $stable(stale_q));
endmodule

// File: rtl/lfm_blank_tmr.sv
module lfm_blank_tmr #(
  parameter int unsigned BW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [BW-1:0] len_i,
  output logic          blank_o
);
  logic          en_q;
  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      en_q <= en_i;
      if (en_i && !en_q)    cnt_q <= len_i;
      else if (!en_i)       cnt_q <= '0;
      else if (cnt_q != '0) cnt_q <= cnt_q - BW'(1);
    end
  end

  assign blank_o = (cnt_q != '0);

  a_r9_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !en_q && len_i != '0) |=> blank_o);

  a_r9_off_when_dis: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !blank_o);
endmodule

// File: rtl/lfm_channel.sv
module lfm_channel #(
  parameter int unsigned LIMIT   = 60,
  parameter int unsigned BLANK_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_i,
  input  logic               vld_i,
  input  logic               en_i,
  input  logic               force_i,
  input  logic               lost_i,
  input  logic [BLANK_W-1:0] blank_len_i,
  output logic               fault_no
);
  logic det_flt;
  logic blank;

  lfm_run_det #(.LIMIT(LIMIT)) u_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!en_i),
    .vld_i (vld_i),
    .bit_i (bit_i),
    .flt_o (det_flt)
  );

  lfm_blank_tmr #(.BW(BLANK_W)) u_blank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .len_i  (blank_len_i),
    .blank_o(blank)
  );

  assign fault_no = ~(det_flt | ~en_i | force_i | lost_i | blank);

  a_r6_dis_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> det_flt);

  a_r9_blank_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank |-> !fault_no);
endmodule

// File: rtl/link_fault_mon.sv
module link_fault_mon #(
  parameter int unsigned NUM_CH    = 2,
  parameter int unsigned CHAR_BITS = lfm_pkg::DEF_CHAR_BITS,
  parameter int unsigned RUN_CHARS = lfm_pkg::DEF_RUN_CHARS,
  parameter int unsigned BLANK_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CH-1:0]  bit_i,
  input  logic [NUM_CH-1:0]  bit_vld_i,
  input  logic [NUM_CH-1:0]  ch_en_i,
  input  logic [NUM_CH-1:0]  rate_force_i,
  input  logic [NUM_CH-1:0]  sig_lost_i,
  input  logic [BLANK_W-1:0] blank_len_i,
  output logic [NUM_CH-1:0]  fault_no
);
  localparam int unsigned LIMIT = CHAR_BITS * RUN_CHARS;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    lfm_channel #(.LIMIT(LIMIT), .BLANK_W(BLANK_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .bit_i      (bit_i[c]),
      .vld_i      (bit_vld_i[c]),
      .en_i       (ch_en_i[c]),
      .force_i    (rate_force_i[c]),
      .lost_i     (sig_lost_i[c]),
      .blank_len_i(blank_len_i),
      .fault_no   (fault_no[c])
    );

    a_r7_force_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rate_force_i[c] |-> !fault_no[c]);

    a_r8_lost_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sig_lost_i[c] |-> !fault_no[c]);
  end
endmodule

// File: tb/sim_link_fault_mon.sv
module sim_link_fault_mon;
  localparam int NCH = 2;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [NCH-1:0] bit_i = '0, bit_vld_i = '0, ch_en_i = '0;
  logic [NCH-1:0] rate_force_i = '0, sig_lost_i = '0;
  logic [15:0]    blank_len_i = 16'd2;
  logic [NCH-1:0] fault_no;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  link_fault_mon u0 (.*);

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic check(input int ch, input logic exp, input string req);
    n_chk++;
    if (fault_no[ch] !== exp) begin
      n_fail++;
      $display("FAIL %s ch%0d fault_no actual=%b expected=%b", req, ch, fault_no[ch], exp);
    end
  endtask

  task automatic send(input int ch, input logic b);
    bit_i[ch] = b; bit_vld_i[ch] = 1'b1;
    tick();
    bit_vld_i[ch] = 1'b0;
  endtask

  task automatic t_reset();
    check(0, 1'b0, "R11"); check(1, 1'b0, "R11");
    ch_en_i = 2'b11; blank_len_i = 16'd0;
    tick(); tick();
    check(0, 1'b0, "R11 stale until transition");
    send(0, 1'b1); check(0, 1'b0, "R11 first bit");
    send(0, 1'b0); check(0, 1'b1, "R3 first transition clears");
    check(1, 1'b0, "R10 ch1 untouched");
    send(1, 1'b0); send(1, 1'b1); check(1, 1'b1, "R5 good link reads high");
  endtask

  task automatic t_run_limit();
    send(0, 1'b1); send(0, 1'b0); // run=1
    for (int i = 0; i < 59; i++) send(0, 1'b0);
    check(0, 1'b1, "R1 run of 60 ok");
    send(0, 1'b0);
    check(0, 1'b0, "R1 run of 61 faults");
    check(1, 1'b1, "R10 ch1 independent");
    for (int i = 0; i < 240; i++) send(0, 1'b0);
    check(0, 1'b0, "R2 saturates on long run");
    send(0, 1'b1);
    check(0, 1'b1, "R3 transition clears");
  endtask

  task automatic t_valid_gate();
    send(0, 1'b0);
    for (int i = 0; i < 80; i++) begin
      bit_i[0] = 1'b0; tick();
    end
    check(0, 1'b1, "R4 invalid bits do not advance run");
    for (int i = 0; i < 60; i++) send(0, 1'b0);
    check(0, 1'b0, "R4 fault after 61 valid");
    bit_i[0] = 1'b1; tick(); tick();
    check(0, 1'b0, "R4 invalid transition ignored");
    send(0, 1'b1);
    check(0, 1'b1, "R3 valid transition clears");
  endtask

  task automatic t_force_lost();
    rate_force_i[0] = 1'b1; #1;
    check(0, 1'b0, "R7 force same cycle");
    check(1, 1'b1, "R10 force ch0 only");
    rate_force_i[0] = 1'b0; #1;
    check(0, 1'b1, "R7 release");
    sig_lost_i[1] = 1'b1; #1;
    check(1, 1'b0, "R8 signal lost");
    check(0, 1'b1, "R10 lost ch1 only");
    sig_lost_i[1] = 1'b0; #1;
    check(1, 1'b1, "R8 release");
  endtask

  task automatic t_disable_blank();
    ch_en_i[0] = 1'b0; #1;
    check(0, 1'b0, "R6 disable same cycle");
    tick(); tick();
    blank_len_i = 16'd5;
    ch_en_i[0] = 1'b1;
    tick(); // load edge
    check(0, 1'b0, "R9 blank start");
    send(0, 1'b0); send(0, 1'b1); send(0, 1'b0); send(0, 1'b1);
    check(0, 1'b0, "R9 still blanking at 4");
    send(0, 1'b0);
    check(0, 1'b1, "R9 released after 5");
    ch_en_i[0] = 1'b0; tick();
    blank_len_i = 16'd0; ch_en_i[0] = 1'b1; tick();
    check(0, 1'b0, "R6 restart needs transition");
    send(0, 1'b0); send(0, 1'b1);
    check(0, 1'b1, "R9 zero length no blank");
  endtask

  initial begin
    #1;
    check(0, 1'b0, "R11 in reset");
    tick(); tick();
    rst_ni = 1'b1;
    t_reset();
    t_run_limit();
    t_valid_gate();
    t_force_lost();
    t_disable_blank();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule